// File: doc/BRIEF.md
# Bridge Internal-Bus Error Reporter

This block sits on the internal-bus side of a PCI/PCI-X bridge. It receives single-cycle strobes for three failure cases: an inbound write that ended in an internal-bus master-abort, an inbound read that ended in a master-abort, and an inbound read that ended in a target-abort. It also receives a strobe that says a system error was seen on the PCI bus. For each strobe it does three things. It asks the transaction engine for the right bus response. It records the event in sticky status bits. It raises a maskable interrupt line.

The read-error response depends on the bus mode. In conventional mode (`bus_mode` = 0) the block asks for a target-abort. In any PCI-X mode (`bus_mode` = 1 or 2; code 3 is treated the same way) it asks for a split completion error message to the requester. Write errors raise the system error output, but only when both enables allow it.

A small response state machine has three states:
- `RSP_IDLE`: no response is issued.
- `RSP_TABORT`: the target-abort request is high.
- `RSP_SPLIT`: the split-error request is high.

The next state is chosen every cycle:
- A read error in conventional mode goes to `RSP_TABORT`.
- A read error in a PCI-X mode goes to `RSP_SPLIT`.
- Any cycle without a read error returns to `RSP_IDLE`.

Each state therefore lasts one cycle per strobe. The system-error pulse comes from its own register in parallel with the state machine.

Five 16-bit registers are reached through a simple write port and a combinational read port:

| Address | Register |
|---|---|
| 0 | Status |
| 1 | Interrupt status |
| 2 | Interrupt mask |
| 3 | Control |
| 4 | Command |

Top module: `brg_err_report`

## Requirements
- R1: After reset, all five registers read 0, and `serr_o`, `tabort_req_o`, `split_err_req_o` and `irq_o` are low.
- R2: An inbound-write master-abort strobe does the following when mask bit 1 and command bit 8 are both set:
  - `serr_o` pulses in the next cycle.
  - Status bits 7 and 14 are set.
  - Interrupt status bit 10 is set.
- R3: When mask bit 1 or command bit 8 is clear, an inbound-write master-abort gives no `serr_o` pulse and leaves status bit 14 and interrupt status bit 10 unchanged. It still sets status bit 7.
- R4: A read master-abort or read target-abort with `bus_mode` = 0 does the following:
  - `tabort_req_o` pulses in the next cycle.
  - Status bit 11 and interrupt status bit 1 are set.
  - A read master-abort also sets status bit 7.
- R5: A read error with `bus_mode` nonzero pulses `split_err_req_o` in the next cycle and sets interrupt status bit 13. It sets neither status bit 11 nor `tabort_req_o`.
- R6: A read target-abort alone never sets status bit 7.
- R7: A `serr_det_i` strobe sets interrupt status bit 4.
- R8: `irq_o` is a register. It goes high on the clock edge after an enabled interrupt status bit is seen set. Each bit has its own gate, and a set gate bit blocks that bit:

  | Interrupt status bit | Blocked by |
  |---|---|
  | 10 | Mask bit 6 |
  | 4 | Control bit 9 |
  | 1 | Mask bit 3 |
  | 13 | Mask bit 10 |

- R9: Status and interrupt status bits are cleared by writing 1 to them. Writing 0 leaves them unchanged. When a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: The mask, control and command registers read back exactly the last value written to them.
- R11: The three response outputs are one-cycle pulses per strobe and return low on the next cycle when there is no new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | 0 conventional, 1 PCI-X mode 1, 2 PCI-X mode 2 |
| ev_wr_mabort | input | 1 | Inbound write ended in internal-bus master-abort |
| ev_rd_mabort | input | 1 | Inbound read ended in internal-bus master-abort |
| ev_rd_tabort | input | 1 | Inbound read ended in internal-bus target-abort |
| serr_det_i | input | 1 | System error seen on the PCI bus |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| serr_o | output | 1 | System error assertion pulse |
| tabort_req_o | output | 1 | Target-abort response request |
| split_err_req_o | output | 1 | Split completion error message request |
| irq_o | output | 1 | Interrupt line |

## Verification
The risky overlap is a software write-1-to-clear that lands in the same cycle as a hardware event that sets the same status bit. Another overlap is a read error that arrives together with a write error, so the system-error pulse and a read response must come out together. The bench provokes both cases on purpose and then keeps hitting them in a long random phase. The random phase draws strobes, bus mode and register writes independently. A behavioural model compares the pulses, the interrupt line and the read-back value every cycle. In a collision the model expects the bit to stay set.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;

    // Bus mode codes
    localparam logic [1:0] MODE_CONV = 2'd0;

    // Register addresses
    localparam int A_STATUS = 0;
    localparam int A_ISTAT  = 1;
    localparam int A_IMASK  = 2;
    localparam int A_CTRL   = 3;
    localparam int A_CMD    = 4;

    // Status register bit positions
    localparam int SR_INT_MABORT  = 7;
    localparam int SR_TABORT_TGT  = 11;
    localparam int SR_SERR_ASSERT = 14;

    // Interrupt status register bit positions
    localparam int IS_TABORT      = 1;
    localparam int IS_SERR_SEEN   = 4;
    localparam int IS_SERR_ASSERT = 10;
    localparam int IS_SPLIT_ERR   = 13;

    // Interrupt mask register bit positions
    localparam int IM_ECC_TA_EN   = 0;
    localparam int IM_SERR_EN     = 1;
    localparam int IM_TABORT      = 3;
    localparam int IM_SERR_ASSERT = 6;
    localparam int IM_SPLIT_ERR   = 10;

    // Control and command register bit positions
    localparam int CT_SERR_SEEN = 9;
    localparam int CM_SERR_EN   = 8;

    // Read-response state machine
    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_TABORT = 2'd1,
        RSP_SPLIT  = 2'd2
    } rsp_state_t;

    // One cycle's worth of error strobes
    typedef struct packed {
        logic wr_mabort;
        logic rd_mabort;
        logic rd_tabort;
        logic serr_seen;
    } err_ev_t;

endpackage

// File: rtl/brg_err_sticky.sv
module brg_err_sticky #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // One register per bit; a set in the same cycle beats a clear.
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic q_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_r <= 1'b0;
            end else if (set_i[b]) begin
                q_r <= 1'b1;
            end else if (clr_i[b]) begin
                q_r <= 1'b0;
            end
        end

        assign q_o[b] = q_r;
    end

    // A bit that was both set and cleared in one cycle must be set afterwards.
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i)) |=> ((q_o & $past(set_i & clr_i)) == $past(set_i & clr_i))); // R9

endmodule

// File: rtl/brg_err_cfg.sv
module brg_err_cfg
    import brg_err_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  imask_o,
    output logic [REG_W-1:0]  ctrl_o,
    output logic [REG_W-1:0]  cmd_o,
    output logic              serr_en_o,
    output logic [REG_W-1:0]  irq_en_o
);

    localparam int NCFG = 3;
    localparam int CFG_BASE = A_IMASK;

    logic [REG_W-1:0] cfg_q [NCFG];

    // Three plain read/write registers at consecutive addresses.
    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (wr_i && (addr_i == ADDR_W'(CFG_BASE + i))) begin
                cfg_q[i] <= wdata_i;
            end
        end
    end

    assign imask_o = cfg_q[0];
    assign ctrl_o  = cfg_q[1];
    assign cmd_o   = cfg_q[2];

    // System-error output is allowed only when both enables are set.
    assign serr_en_o = imask_o[IM_SERR_EN] & cmd_o[CM_SERR_EN];

    // Per-bit interrupt gate; a set mask or control bit blocks its source.
    always_comb begin
        irq_en_o                 = '0;
        irq_en_o[IS_SERR_ASSERT] = ~imask_o[IM_SERR_ASSERT];
        irq_en_o[IS_SERR_SEEN]   = ~ctrl_o[CT_SERR_SEEN];
        irq_en_o[IS_TABORT]      = ~imask_o[IM_TABORT];
        irq_en_o[IS_SPLIT_ERR]   = ~imask_o[IM_SPLIT_ERR];
    end

    // The command register holds what was last written to it.
    AST_CMD_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(A_CMD)) |=> (cmd_o == $past(wdata_i))); // R10

endmodule

// File: rtl/brg_err_resp.sv
module brg_err_resp
    import brg_err_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  err_ev_t          ev_i,
    input  logic [1:0]       bus_mode_i,
    input  logic             serr_en_i,
    output logic             serr_o,
    output logic             tabort_o,
    output logic             split_o,
    output logic [REG_W-1:0] sr_set_o,
    output logic [REG_W-1:0] isr_set_o
);

    rsp_state_t state_q, state_d;
    logic       rd_err;
    logic       serr_fire;
    logic       serr_q;

    assign rd_err    = ev_i.rd_mabort | ev_i.rd_tabort;
    assign serr_fire = ev_i.wr_mabort & serr_en_i;

    // Next-state selection: a read error picks the response that fits the bus mode.
    always_comb begin
        state_d = RSP_IDLE;
        if (rd_err) begin
            state_d = (bus_mode_i == MODE_CONV) ? RSP_TABORT : RSP_SPLIT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // System-error pulse register, parallel to the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            serr_q <= 1'b0;
        end else begin
            serr_q <= serr_fire;
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        tabort_o = 1'b0;
        split_o  = 1'b0;
        unique case (state_q)
            RSP_IDLE:   ;
            RSP_TABORT: tabort_o = 1'b1;
            RSP_SPLIT:  split_o  = 1'b1;
            default:    ;
        endcase
    end

    assign serr_o = serr_q;

    // Status bits to set this cycle
    always_comb begin
        sr_set_o  = '0;
        isr_set_o = '0;
        sr_set_o[SR_INT_MABORT]   = ev_i.wr_mabort | ev_i.rd_mabort;
        sr_set_o[SR_SERR_ASSERT]  = serr_fire;
        isr_set_o[IS_SERR_ASSERT] = serr_fire;
        isr_set_o[IS_SERR_SEEN]   = ev_i.serr_seen;
        if (state_d == RSP_TABORT) begin
            sr_set_o[SR_TABORT_TGT] = 1'b1;
            isr_set_o[IS_TABORT]    = 1'b1;
        end
        if (state_d == RSP_SPLIT) begin
            isr_set_o[IS_SPLIT_ERR] = 1'b1;
        end
    end

    AST_SERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> ($past(ev_i.wr_mabort) && $past(serr_en_i))); // R3
    AST_TABORT_CONV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        tabort_o |-> ($past(rd_err) && $past(bus_mode_i) == MODE_CONV)); // R4
    AST_SPLIT_PCIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        split_o |-> ($past(rd_err) && $past(bus_mode_i) != MODE_CONV)); // R5
    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tabort_o && !rd_err) |=> !tabort_o); // R11

endmodule

// File: rtl/brg_err_report.sv
module brg_err_report
    import brg_err_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_mode,
    input  logic              ev_wr_mabort,
    input  logic              ev_rd_mabort,
    input  logic              ev_rd_tabort,
    input  logic              serr_det_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              serr_o,
    output logic              tabort_req_o,
    output logic              split_err_req_o,
    output logic              irq_o
);

    err_ev_t          ev;
    logic [REG_W-1:0] imask, ctrl, cmd, irq_en;
    logic             serr_en;
    logic [REG_W-1:0] sr_set, isr_set, sr_clr, isr_clr;
    logic [REG_W-1:0] sr_q, isr_q;
    logic             irq_q;

    assign ev.wr_mabort = ev_wr_mabort;
    assign ev.rd_mabort = ev_rd_mabort;
    assign ev.rd_tabort = ev_rd_tabort;
    assign ev.serr_seen = serr_det_i;

    // Write-1-to-clear strobes for the two sticky registers
    assign sr_clr  = (reg_wr && reg_addr == ADDR_W'(A_STATUS)) ? reg_wdata : '0;
    assign isr_clr = (reg_wr && reg_addr == ADDR_W'(A_ISTAT))  ? reg_wdata : '0;

    brg_err_cfg #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .imask_o   (imask),
        .ctrl_o    (ctrl),
        .cmd_o     (cmd),
        .serr_en_o (serr_en),
        .irq_en_o  (irq_en)
    );

    brg_err_resp #(.REG_W(REG_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .bus_mode_i (bus_mode),
        .serr_en_i  (serr_en),
        .serr_o     (serr_o),
        .tabort_o   (tabort_req_o),
        .split_o    (split_err_req_o),
        .sr_set_o   (sr_set),
        .isr_set_o  (isr_set)
    );

    brg_err_sticky #(.W(REG_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sr_set),
        .clr_i (sr_clr),
        .q_o   (sr_q)
    );

    brg_err_sticky #(.W(REG_W)) u_istat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (isr_set),
        .clr_i (isr_clr),
        .q_o   (isr_q)
    );

    // Interrupt line: registered OR of the enabled interrupt status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(isr_q & irq_en);
        end
    end

    assign irq_o = irq_q;

    // Read-back multiplexer
    always_comb begin
        case (reg_addr)
            ADDR_W'(A_STATUS): reg_rdata = sr_q;
            ADDR_W'(A_ISTAT):  reg_rdata = isr_q;
            ADDR_W'(A_IMASK):  reg_rdata = imask;
            ADDR_W'(A_CTRL):   reg_rdata = ctrl;
            ADDR_W'(A_CMD):    reg_rdata = cmd;
            default:           reg_rdata = '0;
        endcase
    end

    AST_SERR_MARKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> (sr_q[SR_SERR_ASSERT] && isr_q[IS_SERR_ASSERT])); // R2
    AST_TABORT_ALONE_NO_MA: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rd_tabort && !ev_rd_mabort && !ev_wr_mabort && !sr_q[SR_INT_MABORT])
        |=> !sr_q[SR_INT_MABORT]); // R6
    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(isr_q) != '0)); // R8
    AST_SEEN_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        serr_det_i |=> isr_q[IS_SERR_SEEN]); // R7

endmodule

// File: tb/brg_err_report_bench.sv
`timescale 1ns/1ps
module brg_err_report_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'd0;
    logic        ev_wr_mabort = 1'b0;
    logic        ev_rd_mabort = 1'b0;
    logic        ev_rd_tabort = 1'b0;
    logic        serr_det_i = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        serr_o, tabort_req_o, split_err_req_o, irq_o;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference state
    logic [15:0] m_reg [5];
    logic        m_serr = 0, m_ta = 0, m_sc = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    brg_err_report u_brg_err_report (
        .clk (clk), .rst_n (rst_n), .bus_mode (bus_mode),
        .ev_wr_mabort (ev_wr_mabort), .ev_rd_mabort (ev_rd_mabort),
        .ev_rd_tabort (ev_rd_tabort), .serr_det_i (serr_det_i),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .serr_o (serr_o), .tabort_req_o (tabort_req_o),
        .split_err_req_o (split_err_req_o), .irq_o (irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] gate_of();
        logic [15:0] g = 16'h0;
        g[10] = !m_reg[2][6];
        g[4]  = !m_reg[3][9];
        g[1]  = !m_reg[2][3];
        g[13] = !m_reg[2][10];
        return g;
    endfunction

    // Advance the model by one clock using the inputs held over the edge.
    task automatic model_step();
        logic [15:0] sset = 16'h0, iset = 16'h0, clr = 16'h0;
        logic rd = ev_rd_mabort | ev_rd_tabort;
        logic irq_n = |(m_reg[1] & gate_of());
        logic serr_n = ev_wr_mabort & m_reg[2][1] & m_reg[4][8];
        m_ta = rd && (bus_mode == 2'd0);
        m_sc = rd && (bus_mode != 2'd0);
        m_serr = serr_n;
        m_irq = irq_n;
        if (ev_wr_mabort || ev_rd_mabort) sset[7] = 1;
        if (serr_n) begin sset[14] = 1; iset[10] = 1; end
        if (m_ta) begin sset[11] = 1; iset[1] = 1; end
        if (m_sc) iset[13] = 1;
        if (serr_det_i) iset[4] = 1;
        if (reg_wr) clr = reg_wdata;
        m_reg[0] = (m_reg[0] & ~((reg_wr && reg_addr == 0) ? clr : 16'h0)) | sset;
        m_reg[1] = (m_reg[1] & ~((reg_wr && reg_addr == 1) ? clr : 16'h0)) | iset;
        if (reg_wr && reg_addr >= 2 && reg_addr <= 4) m_reg[reg_addr] = reg_wdata;
    endtask

    task automatic compare_all();
        check("R2", "serr_o", {15'h0, serr_o}, {15'h0, m_serr});
        check("R4", "tabort_req_o", {15'h0, tabort_req_o}, {15'h0, m_ta});
        check("R5", "split_err_req_o", {15'h0, split_err_req_o}, {15'h0, m_sc});
        check("R8", "irq_o", {15'h0, irq_o}, {15'h0, m_irq});
        if (reg_addr <= 4) check("R9", "reg_rdata", reg_rdata, m_reg[reg_addr]);
    endtask

    // One clock: edge, model update, drop strobes, compare
    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        ev_wr_mabort = 0; ev_rd_mabort = 0; ev_rd_tabort = 0;
        serr_det_i = 0; reg_wr = 0;
        #0.5;
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        reg_addr = a;
        #0.5;
        check(req, "readback", reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) m_reg[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #0.5;
        // R1: reset state
        check("R1", "serr_o", {15'h0, serr_o}, 16'h0);
        check("R1", "tabort", {15'h0, tabort_req_o}, 16'h0);
        check("R1", "split", {15'h0, split_err_req_o}, 16'h0);
        check("R1", "irq", {15'h0, irq_o}, 16'h0);
        for (int a = 0; a < 5; a++) rd_chk("R1", 3'(a), 16'h0);

        // R10: configuration read-back
        wr(3'd2, 16'h0002);
        wr(3'd4, 16'h0100);
        wr(3'd3, 16'h5a5a);
        rd_chk("R10", 3'd2, 16'h0002);
        rd_chk("R10", 3'd4, 16'h0100);
        rd_chk("R10", 3'd3, 16'h5a5a);
        wr(3'd3, 16'h0000);

        // R2: write master-abort with both enables
        ev_wr_mabort = 1; tick();
        check("R2", "serr pulse", {15'h0, serr_o}, 16'h1);
        check("R8", "irq not yet", {15'h0, irq_o}, 16'h0);
        tick();
        check("R11", "serr back low", {15'h0, serr_o}, 16'h0);
        check("R8", "irq after gate", {15'h0, irq_o}, 16'h1);
        rd_chk("R2", 3'd0, 16'h4080);
        rd_chk("R2", 3'd1, 16'h0400);

        // R9: write-1-to-clear, write-0 no effect
        wr(3'd0, 16'h4080);
        rd_chk("R9", 3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        rd_chk("R9", 3'd1, 16'h0400);
        wr(3'd1, 16'h0400);
        rd_chk("R9", 3'd1, 16'h0000);
        tick();
        check("R8", "irq falls", {15'h0, irq_o}, 16'h0);

        // R3: command enable cleared
        wr(3'd4, 16'h0000);
        ev_wr_mabort = 1; tick();
        check("R3", "no serr", {15'h0, serr_o}, 16'h0);
        rd_chk("R3", 3'd0, 16'h0080);
        rd_chk("R3", 3'd1, 16'h0000);
        wr(3'd0, 16'hffff);

        // R4: conventional read master-abort
        bus_mode = 2'd0;
        ev_rd_mabort = 1; tick();
        check("R4", "tabort pulse", {15'h0, tabort_req_o}, 16'h1);
        tick();
        check("R11", "tabort low", {15'h0, tabort_req_o}, 16'h0);
        rd_chk("R4", 3'd0, 16'h0880);
        rd_chk("R4", 3'd1, 16'h0002);
        wr(3'd0, 16'hffff);

        // R6: read target-abort alone, conventional
        ev_rd_tabort = 1; tick();
        rd_chk("R6", 3'd0, 16'h0800);

        // R5: PCI-X modes request split completion error
        wr(3'd1, 16'hffff);
        bus_mode = 2'd2;
        ev_rd_tabort = 1; tick();
        check("R5", "split pulse", {15'h0, split_err_req_o}, 16'h1);
        check("R5", "no tabort", {15'h0, tabort_req_o}, 16'h0);
        rd_chk("R5", 3'd1, 16'h2000);
        bus_mode = 2'd1;
        ev_rd_mabort = 1; tick();
        check("R5", "split mode1", {15'h0, split_err_req_o}, 16'h1);
        rd_chk("R5", 3'd0, 16'h0880);

        // R7: bus system error seen
        serr_det_i = 1; tick();
        rd_chk("R7", 3'd1, 16'h2010);

        // R8: all gates closed keeps irq low
        wr(3'd2, 16'h0448);
        wr(3'd3, 16'h0200);
        tick(); tick();
        check("R8", "all masked", {15'h0, irq_o}, 16'h0);

        // R9: set beats clear in the same cycle; write and read errors together
        wr(3'd2, 16'h0002); wr(3'd4, 16'h0100);
        bus_mode = 2'd0;
        reg_wr = 1; reg_addr = 3'd0; reg_wdata = 16'h0080;
        ev_rd_mabort = 1; ev_wr_mabort = 1;
        tick();
        check("R9", "collision", {15'h0, serr_o & tabort_req_o}, 16'h1);
        rd_chk("R9", 3'd0, 16'h4880);

        // Random phase
        for (int c = 0; c < 3000; c++) begin
            logic [31:0] r = $urandom;
            bus_mode     = r[1:0];
            ev_wr_mabort = r[2] & r[3];
            ev_rd_mabort = r[4] & r[5];
            ev_rd_tabort = r[6] & r[7];
            serr_det_i   = r[8] & r[9];
            reg_wr       = r[10] & r[11];
            reg_addr     = 3'(r[14:12] % 5);
            reg_wdata    = r[31:16];
            tick();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule